// File: doc/BRIEF.md
# Reset-Time Strap Mode Sampler

This block reads two active-low configuration straps while reset is held and chooses one of three startup modes for the controller: built-in self-test, output float, or normal start. It registers the straps on every clock edge during reset, so the mode that sticks is the one seen on the last edge before reset is released. In float mode it clears a global output-enable that the surrounding chip uses to tri-state all of its outputs and bidirectional pins. In self-test mode it issues a one-cycle request to the self-test engine just after reset ends.

One of the two straps shares its pin with a run-time address-latch-enable input. While reset is held and during the reset sequence that follows, the pin is read only as a strap. When the reset-sequence busy indication goes inactive, the block hands the pin over and passes its level to the run-time logic as the latch-enable. Float mode blocks that path, so the pin has no effect while the outputs are tri-stated.

Top module: `strap_mode_sampler`

## Requirements
- R1: While `rst` is 1, the mode register loads the decoded straps on every rising clock edge. The value loaded on the last edge with `rst` = 1 is the latched mode, and earlier strap values are overwritten.
- R2: With `sharedPin` = 1 and `testStrapN` = 0, the latched mode is self-test, and `modeOut` = 2'b01.
- R3: With `sharedPin` = 0 and `testStrapN` = 0, the latched mode is float. `modeOut` = 2'b10 and `outEnable` = 0.
- R4: With `testStrapN` = 1, the latched mode is normal whatever the value of `sharedPin`. `modeOut` = 2'b00 and `outEnable` = 1.
- R5: Once float mode is latched, `outEnable` stays 0 for every cycle until `rst` is asserted again. A new reset with other strap values sets it back to 1.
- R6: `selfTestReq` is 1 for exactly one cycle, in the cycle after the first rising edge with `rst` = 0, and only if self-test mode is latched. In every other case it is 0.
- R7: `latchEnOut` is 0 during reset and until `initBusyN` has been sampled as 1 on a rising edge with `rst` = 0. After that it follows `sharedPin` (active high) until the next reset.
- R8: While float mode is latched, `latchEnOut` is 0 whatever the levels of `sharedPin` and `initBusyN`.
- R9: After reset is released, changes on `sharedPin` and `testStrapN` do not change `modeOut` or `outEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; the straps are sampled while it is 1 |
| sharedPin | input | 1 | Float strap (active low) during reset; latch-enable input after hand-over |
| testStrapN | input | 1 | Self-test strap, active low |
| initBusyN | input | 1 | Reset-sequence busy, active low; 1 means the sequence is complete |
| outEnable | output | 1 | 1 lets the controller drive its outputs; 0 tri-states them |
| selfTestReq | output | 1 | One-cycle start pulse for the self-test engine |
| modeOut | output | 2 | Latched mode: 00 normal, 01 self-test, 10 float |
| latchEnOut | output | 1 | Run-time address-latch-enable passed through from the shared pin |

## Verification
The self-test pulse and the pin hand-over can land in the same cycle. This happens when `initBusyN` is already 1 at the moment reset is released. The bench sets up exactly that case: self-test straps, with `initBusyN` and `sharedPin` held at 1 through the release. It then checks, on the first falling edge after release, that `selfTestReq` and `latchEnOut` are both 1, and that one cycle later only the pulse has gone back to 0. The same release is repeated with float straps to confirm that the hand-over still happens but `latchEnOut` stays 0.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BIST   = 2'b01,
    MODE_FLOAT  = 2'b10
  } startMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleEn;   // straps are captured this edge
    logic firstRun;   // first edge after reset release
    logic runtimePin; // shared pin now belongs to run-time logic
  } ctlStrobe_t;

  function automatic startMode_t decodeStraps(input logic floatN, input logic testN);
    if (testN)       return MODE_NORMAL;
    else if (floatN) return MODE_BIST;
    else             return MODE_FLOAT;
  endfunction

endpackage

// File: rtl/strap_ctl.sv
module strap_ctl
  import strap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       initBusyN,
  output ctlStrobe_t strobe
);

  logic rstDly;
  logic handOver;

  always_ff @(posedge clk) begin
    rstDly <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst)            handOver <= 1'b0;
    else if (initBusyN) handOver <= 1'b1;
  end

  always_comb begin
    strobe.sampleEn   = rst;
    strobe.firstRun   = !rst && rstDly;
    strobe.runtimePin = handOver;
  end

  // hand-over is sticky until the next reset
  assert_handover_hold_R7: assert property (@(posedge clk) disable iff (rst)
    handOver |=> handOver);

  // hand-over cannot happen before completion has been seen
  assert_handover_cause_R7: assert property (@(posedge clk) disable iff (rst)
    !handOver && !initBusyN |=> !handOver);

endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter bit LATCH_EN_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t strobe,
  input  logic       sharedPin,
  input  logic       testStrapN,
  output logic       outEnable,
  output logic       selfTestReq,
  output startMode_t mode,
  output logic       latchEn
);

  logic pinLevel;

  always_ff @(posedge clk) begin
    if (strobe.sampleEn) mode <= decodeStraps(sharedPin, testStrapN);
  end

  always_ff @(posedge clk) begin
    if (rst) selfTestReq <= 1'b0;
    else     selfTestReq <= strobe.firstRun && (mode == MODE_BIST);
  end

  generate
    if (LATCH_EN_ACTIVE_HIGH) begin : g_leHigh
      assign pinLevel = sharedPin;
    end else begin : g_leLow
      assign pinLevel = !sharedPin;
    end
  endgenerate

  assign outEnable = (mode != MODE_FLOAT);
  assign latchEn   = strobe.runtimePin && (mode != MODE_FLOAT) && pinLevel;

  // mode holds after the release edge
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobe.firstRun |-> $stable(mode));

  // float is sticky until reset
  assert_float_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !outEnable |=> !outEnable);

  // pulse lasts one cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    selfTestReq |=> !selfTestReq);

  // pulse only in self-test mode
  assert_pulse_mode_R6: assert property (@(posedge clk) disable iff (rst)
    selfTestReq |-> mode == MODE_BIST);

  // float blocks the latch-enable path
  assert_float_blocks_le_R8: assert property (@(posedge clk) disable iff (rst)
    !outEnable |-> !latchEn);

endmodule

// File: rtl/strap_mode_sampler.sv
module strap_mode_sampler
  import strap_pkg::*;
#(
  parameter bit LATCH_EN_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sharedPin,
  input  logic       testStrapN,
  input  logic       initBusyN,
  output logic       outEnable,
  output logic       selfTestReq,
  output logic [1:0] modeOut,
  output logic       latchEnOut
);

  ctlStrobe_t strobe;
  startMode_t mode;

  strap_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .initBusyN (initBusyN),
    .strobe    (strobe)
  );

  strap_dp #(.LATCH_EN_ACTIVE_HIGH(LATCH_EN_ACTIVE_HIGH)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .sharedPin   (sharedPin),
    .testStrapN  (testStrapN),
    .outEnable   (outEnable),
    .selfTestReq (selfTestReq),
    .mode        (mode),
    .latchEn     (latchEnOut)
  );

  assign modeOut = mode;

endmodule

// File: tb/strap_mode_sampler_tb.sv
module strap_mode_sampler_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sharedPin = 1'b1;
  logic testStrapN = 1'b1;
  logic initBusyN = 1'b0;
  logic outEnable, selfTestReq, latchEnOut;
  logic [1:0] modeOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strap_mode_sampler u_dut (
    .clk(clk), .rst(rst), .sharedPin(sharedPin), .testStrapN(testStrapN),
    .initBusyN(initBusyN), .outEnable(outEnable), .selfTestReq(selfTestReq),
    .modeOut(modeOut), .latchEnOut(latchEnOut)
  );

  // {floatN, testN, expMode[1:0], expOe, expPulse}
  localparam logic [5:0] VEC [4] = '{
    6'b10_01_1_1,   // R2 self-test
    6'b00_10_0_0,   // R3 float
    6'b01_00_1_0,   // R4 normal, float strap active
    6'b11_00_1_0    // R4 normal, float strap inactive
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // hold reset for n edges with given straps, release at a falling edge
  task automatic doReset(input logic fN, input logic tN, input int n);
    @(negedge clk);
    rst = 1'b1; sharedPin = fN; testStrapN = tN;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // reset state
    initBusyN = 1'b1;
    doReset(1'b0, 1'b0, 2);
    rst = 1'b1;
    #1;
    check("R1 reset float oe", int'(outEnable), 0);
    check("R7 reset le", int'(latchEnOut), 0);
    check("R6 reset pulse", int'(selfTestReq), 0);

    // table walk
    foreach (VEC[i]) begin
      initBusyN = 1'b0;
      doReset(VEC[i][5], VEC[i][4], 3);
      @(negedge clk);
      check("R2-4 mode", int'(modeOut), int'(VEC[i][3:2]));
      check("R3/R4 oe", int'(outEnable), int'(VEC[i][1]));
      check("R6 pulse", int'(selfTestReq), int'(VEC[i][0]));
      sharedPin = 1'b1;
      @(negedge clk);
      check("R6 pulse end", int'(selfTestReq), 0);
      check("R7 le before handover", int'(latchEnOut), 0);
      testStrapN = ~testStrapN;
      initBusyN = 1'b1;
      @(negedge clk);
      check("R9 mode after straps move", int'(modeOut), int'(VEC[i][3:2]));
      check("R7/R8 le after handover", int'(latchEnOut), int'(VEC[i][1]));
      sharedPin = 1'b0;
      #1;
      check("R7 le follows pin", int'(latchEnOut), 0);
      check("R9 oe stable", int'(outEnable), int'(VEC[i][1]));
    end

    // R1 last edge wins: float then normal
    initBusyN = 1'b0;
    doReset(1'b0, 1'b0, 3);
    rst = 1'b1; testStrapN = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 last edge normal", int'(modeOut), 0);
    check("R1 oe", int'(outEnable), 1);

    // R1 normal then float on the last edge
    doReset(1'b1, 1'b1, 3);
    rst = 1'b1; sharedPin = 1'b0; testStrapN = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 last edge float", int'(modeOut), 2);

    // R5 sticky float across activity
    for (int k = 0; k < 20; k++) begin
      sharedPin = k[0]; testStrapN = k[1]; initBusyN = k[2];
      @(negedge clk);
      check("R5 float sticky", int'(outEnable), 0);
      check("R8 le blocked", int'(latchEnOut), 0);
    end
    doReset(1'b1, 1'b1, 2);
    @(negedge clk);
    check("R5 released by reset", int'(outEnable), 1);

    // R6/R7 same cycle: self-test pulse and hand-over together
    initBusyN = 1'b1;
    doReset(1'b1, 1'b0, 2);
    sharedPin = 1'b1;
    @(negedge clk);
    check("R6 pulse with handover", int'(selfTestReq), 1);
    check("R7 le with pulse", int'(latchEnOut), 1);
    @(negedge clk);
    check("R6 pulse gone", int'(selfTestReq), 0);
    check("R7 le stays", int'(latchEnOut), 1);

    // R8 float with early completion
    doReset(1'b0, 1'b0, 2);
    sharedPin = 1'b1;
    @(negedge clk);
    check("R8 float early handover", int'(latchEnOut), 0);
    check("R6 no pulse in float", int'(selfTestReq), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule